// File: doc/BRIEF.md
# ADC Conversion Sequencer and Pacer

This block decides when a five-input successive-approximation converter starts a conversion and which input it samples. Control inputs give a single-shot start request, a free-running enable, a channel select, a round-robin channel mask and a divider with an integer and a fractional part. The block drives a one-cycle start strobe and a channel index to the converter. It waits for the converter's done pulse and then publishes the result, the channel and the converter's error flag as a one-cycle result pulse. The result stays on the data output until the next conversion completes.

In free-running mode, conversions are spaced by a programmable average period of one plus the divider. The fractional part is spread over successive periods by an error accumulator, so the long-run average is exact. A start is never issued while a conversion is still in flight, so any period shorter than the converter's latency collapses to back-to-back operation. When the round-robin mask is non-zero, the channel steps to the next enabled input after each conversion. The step wraps from input 4 to input 0.

Top module: `adc_seq_pacer`

## Requirements
- R1: Channel indices 0 to 4 are valid, where 0 to 3 are external inputs and 4 is the temperature input. With a zero round-robin mask, the strobe carries the channel select. A select value above 4 is ignored and the previous channel is kept.
- R2: A single-shot request sampled while idle produces exactly one `conv_start` pulse in the following cycle. `ready` is low from that cycle until the cycle in which the result pulse appears, and `ready` is high in that cycle.
- R3: A single-shot request made while a conversion is in progress has no effect. No extra strobe is produced.
- R4: One cycle after the converter's done pulse, `res_valid` is high for exactly one cycle. In that cycle `res_data` carries the converter's 12-bit result, `res_ch` the channel converted and `res_err` the converter's error flag. `res_data` then holds.
- R5: When `run_en` rises while the block is idle, a strobe follows in the next cycle. Strobes then repeat until `run_en` is cleared. After that, no further strobe occurs.
- R6: With both divider parts zero in free-running mode, each new strobe comes in the cycle right after the previous result pulse.
- R7: With an integer divider D and a zero fraction, where 1+D is at least the converter's start-to-result turnaround, consecutive strobes are exactly 1+D cycles apart.
- R8: A divider whose period is shorter than the turnaround is clamped. With a converter that answers 94 cycles after the strobe, strobes are 96 cycles apart.
- R9: With fraction F/256, each free-running period is 1+D or 2+D. Carries come from an 8-bit accumulator that starts at zero when `run_en` is set. For example, D=150 and F=128 give 151, 152, 151, 152.
- R10: With a non-zero mask, each conversion uses the current channel. After each result, the channel moves to the next index whose mask bit is set, skipping cleared bits and wrapping 4 to 0. A single-bit mask stays on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_once | input | 1 | Single-shot conversion request |
| run_en | input | 1 | Free-running enable |
| ch_sel | input | 3 | Channel select (0 to 4) |
| rr_mask | input | 5 | Round-robin participants, bit n for input n; zero disables |
| div_int | input | 16 | Divider integer part |
| div_frac | input | 8 | Divider fraction in 1/256 units |
| conv_start | output | 1 | One-cycle start strobe to converter |
| conv_ch | output | 3 | Channel index for the converter |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | 12 | Converter result, valid with done |
| conv_err | input | 1 | Converter error flag, valid with done |
| ready | output | 1 | High when no conversion is in progress |
| res_valid | output | 1 | One-cycle result pulse |
| res_data | output | 12 | Last result |
| res_ch | output | 3 | Channel of last result |
| res_err | output | 1 | Error flag of last result |

## Verification
A single-shot request driven in cycle c yields the strobe in c+1. With the bench's converter answering 94 cycles after the strobe, the result pulse and the return of `ready` fall in c+96. The bench records the cycle index of every strobe and result pulse from a monitor that samples on the falling edge. Each check compares those recorded indices, and the values captured with them, against the cycle numbers derived above. In free-running mode, the spacing between recorded strobes is compared with the bench's own computation of the period sequence, clamp and fractional carry.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_CH = 5;
  localparam int CH_W   = $clog2(NUM_CH);

  // Next enabled channel after cur, wrapping; cur itself if it is the only one.
  function automatic logic [CH_W-1:0] rr_next(input logic [CH_W-1:0] cur,
                                              input logic [NUM_CH-1:0] mask);
    logic [CH_W-1:0] pick;
    int v;
    pick = cur;
    for (int k = NUM_CH; k >= 1; k--) begin
      v = (int'(cur) + k) % NUM_CH;
      if (mask[CH_W'(v)]) pick = CH_W'(v);
    end
    return pick;
  endfunction

  function automatic logic ch_is_valid(input logic [CH_W-1:0] ch);
    return int'(ch) < NUM_CH;
  endfunction
endpackage

// File: rtl/adc_ch_sel.sv
module adc_ch_sel
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_W-1:0]   sel_in,
  input  logic [NUM_CH-1:0] rr_mask,
  input  logic              advance,
  output logic [CH_W-1:0]   cur_ch
);
  logic rr_on;
  assign rr_on = |rr_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_ch <= '0;
    end else if (!rr_on) begin
      if (ch_is_valid(sel_in)) cur_ch <= sel_in;
    end else if (advance) begin
      cur_ch <= rr_next(cur_ch, rr_mask);
    end
  end

  // R1
  ch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_ch) < NUM_CH);

  // R10
  rr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && rr_on) |=> (rr_mask[cur_ch] || rr_mask != $past(rr_mask)));
endmodule

// File: rtl/adc_pacer.sv
module adc_pacer #(
  parameter int DIV_INT_W  = 16,
  parameter int DIV_FRAC_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_en,
  input  logic                  launch,
  input  logic [DIV_INT_W-1:0]  div_int,
  input  logic [DIV_FRAC_W-1:0] div_frac,
  output logic                  due
);
  localparam int PER_W = DIV_INT_W + 1;

  logic                  armed;
  logic [PER_W-1:0]      cnt;
  logic [PER_W-1:0]      period;
  logic [DIV_FRAC_W-1:0] acc;
  logic [DIV_FRAC_W:0]   acc_sum;
  logic                  zero_div;

  function automatic logic [PER_W-1:0] period_of(input logic [DIV_INT_W-1:0] ip,
                                                 input logic carry);
    return {1'b0, ip} + PER_W'(1) + PER_W'(carry);
  endfunction

  assign acc_sum  = {1'b0, acc} + {1'b0, div_frac};
  assign zero_div = (div_int == '0) && (div_frac == '0);
  assign due      = !armed || zero_div || (cnt >= period);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_en) begin
      armed  <= 1'b0;
      acc    <= '0;
      cnt    <= '0;
      period <= '0;
    end else if (launch) begin
      armed  <= 1'b1;
      acc    <= acc_sum[DIV_FRAC_W-1:0];
      period <= period_of(div_int, acc_sum[DIV_FRAC_W]);
      cnt    <= PER_W'(1);
    end else if (cnt != '1) begin
      cnt <= cnt + PER_W'(1);
    end
  end

  // R7
  pace_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && armed && !zero_div) |-> (cnt >= period));

  // R9
  period_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(launch) && run_en && $past(run_en) && $stable(div_int)) |->
      (period == {1'b0, div_int} + PER_W'(1) || period == {1'b0, div_int} + PER_W'(2)));
endmodule

// File: rtl/adc_conv_ctl.sv
module adc_conv_ctl
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_once,
  input  logic             run_en,
  input  logic             due,
  input  logic [CH_W-1:0]  cur_ch,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  input  logic             conv_err,
  output logic             launch,
  output logic             accept,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_ch,
  output logic             ready,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic [CH_W-1:0]  res_ch,
  output logic             res_err
);
  typedef enum logic {ST_IDLE, ST_BUSY} st_t;
  st_t state;

  assign ready  = (state == ST_IDLE);
  assign launch = ready && (start_once || (run_en && due));
  assign accept = (state == ST_BUSY) && conv_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      conv_start <= 1'b0;
      conv_ch    <= '0;
      res_valid  <= 1'b0;
      res_data   <= '0;
      res_ch     <= '0;
      res_err    <= 1'b0;
    end else begin
      conv_start <= launch;
      res_valid  <= accept;
      if (launch) begin
        state   <= ST_BUSY;
        conv_ch <= cur_ch;
      end else if (accept) begin
        state    <= ST_IDLE;
        res_data <= conv_result;
        res_ch   <= conv_ch;
        res_err  <= conv_err;
      end
    end
  end

  // R3
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(ready));

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R4
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R4
  res_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(conv_done));

  // R4
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_data));
endmodule

// File: rtl/adc_seq_pacer.sv
module adc_seq_pacer
  import adc_seq_pkg::*;
#(
  parameter int RES_W      = 12,
  parameter int DIV_INT_W  = 16,
  parameter int DIV_FRAC_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_once,
  input  logic                  run_en,
  input  logic [CH_W-1:0]       ch_sel,
  input  logic [NUM_CH-1:0]     rr_mask,
  input  logic [DIV_INT_W-1:0]  div_int,
  input  logic [DIV_FRAC_W-1:0] div_frac,
  output logic                  conv_start,
  output logic [CH_W-1:0]       conv_ch,
  input  logic                  conv_done,
  input  logic [RES_W-1:0]      conv_result,
  input  logic                  conv_err,
  output logic                  ready,
  output logic                  res_valid,
  output logic [RES_W-1:0]      res_data,
  output logic [CH_W-1:0]       res_ch,
  output logic                  res_err
);
  logic            launch_w;
  logic            accept_w;
  logic            due_w;
  logic [CH_W-1:0] cur_ch_w;

  adc_ch_sel u_chsel (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_in  (ch_sel),
    .rr_mask (rr_mask),
    .advance (accept_w),
    .cur_ch  (cur_ch_w)
  );

  adc_pacer #(.DIV_INT_W(DIV_INT_W), .DIV_FRAC_W(DIV_FRAC_W)) u_pace (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .launch   (launch_w),
    .div_int  (div_int),
    .div_frac (div_frac),
    .due      (due_w)
  );

  adc_conv_ctl #(.RES_W(RES_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_once  (start_once),
    .run_en      (run_en),
    .due         (due_w),
    .cur_ch      (cur_ch_w),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .conv_err    (conv_err),
    .launch      (launch_w),
    .accept      (accept_w),
    .conv_start  (conv_start),
    .conv_ch     (conv_ch),
    .ready       (ready),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .res_ch      (res_ch),
    .res_err     (res_err)
  );

  // R1
  strobe_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (int'(conv_ch) < NUM_CH));

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !ready);
endmodule

// File: tb/sim_adc_seq_pacer.sv
module sim_adc_seq_pacer;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 94;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_once = 1'b0;
  logic        run_en = 1'b0;
  logic [2:0]  ch_sel = 3'd0;
  logic [4:0]  rr_mask = 5'd0;
  logic [15:0] div_int = 16'd0;
  logic [7:0]  div_frac = 8'd0;
  logic        conv_start;
  logic [2:0]  conv_ch;
  logic        conv_done = 1'b0;
  logic [11:0] conv_result = 12'd0;
  logic        conv_err = 1'b0;
  logic        ready;
  logic        res_valid;
  logic [11:0] res_data;
  logic [2:0]  res_ch;
  logic        res_err;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int n_st = 0;
  int n_res = 0;
  int st_at [0:255];
  int st_ch [0:255];
  int res_at [0:255];
  int res_d [0:255];
  int res_c [0:255];
  int res_e [0:255];
  int model_cnt = 0;
  logic [2:0] model_ch = 3'd0;
  logic [8:0] model_seq = 9'd0;
  logic       err_inject = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_pacer u0 (
    .clk(clk), .rst_n(rst_n), .start_once(start_once), .run_en(run_en),
    .ch_sel(ch_sel), .rr_mask(rr_mask), .div_int(div_int), .div_frac(div_frac),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_result(conv_result), .conv_err(conv_err), .ready(ready),
    .res_valid(res_valid), .res_data(res_data), .res_ch(res_ch), .res_err(res_err)
  );

  // Fixed-latency converter: done LAT cycles after the strobe.
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) begin
      model_cnt <= LAT - 1;
      model_ch  <= conv_ch;
    end else if (model_cnt == 1) begin
      model_cnt   <= 0;
      conv_done   <= 1'b1;
      conv_result <= {model_ch, model_seq};
      conv_err    <= err_inject;
      model_seq   <= model_seq + 9'd1;
    end else if (model_cnt > 1) begin
      model_cnt <= model_cnt - 1;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (conv_start && n_st < 256) begin
      st_at[n_st] = cyc + 1;
      st_ch[n_st] = int'(conv_ch);
      n_st = n_st + 1;
    end
    if (res_valid && n_res < 256) begin
      res_at[n_res] = cyc + 1;
      res_d[n_res]  = int'(res_data);
      res_c[n_res]  = int'(res_ch);
      res_e[n_res]  = int'(res_err);
      n_res = n_res + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // After this returns, cyc holds the index of the current cycle.
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic pulse_start();
    start_once = 1'b1;
    tick(1);
    start_once = 1'b0;
  endtask

  task automatic t_reset();
    chk(ready == 1'b1, "R2", "ready after reset", int'(ready), 1);
    chk(conv_start == 1'b0 && res_valid == 1'b0, "R4", "strobes idle after reset",
        int'(conv_start) + int'(res_valid), 0);
  endtask

  task automatic t_single();
    int c, s0, r0;
    ch_sel = 3'd2; tick(2);
    s0 = n_st; r0 = n_res; c = cyc;
    pulse_start();
    tick(3);
    chk(ready == 1'b0, "R2", "ready low while busy", int'(ready), 0);
    tick(100);
    chk(n_st == s0 + 1, "R2", "one strobe", n_st - s0, 1);
    chk(st_at[s0] == c + 1, "R2", "strobe cycle", st_at[s0], c + 1);
    chk(st_ch[s0] == 2, "R1", "channel", st_ch[s0], 2);
    chk(res_at[r0] == c + 96, "R2", "result/ready cycle", res_at[r0], c + 96);
    chk(res_c[r0] == 2, "R4", "result channel", res_c[r0], 2);
    chk(res_d[r0] == int'(res_data), "R4", "result held", int'(res_data), res_d[r0]);
    chk((res_d[r0] >> 9) == 2, "R4", "result payload channel", res_d[r0] >> 9, 2);
    chk(ready == 1'b1, "R2", "ready back", int'(ready), 1);
  endtask

  task automatic t_busy_ignore();
    int s0;
    s0 = n_st;
    pulse_start();
    tick(40);
    pulse_start();
    tick(150);
    chk(n_st == s0 + 1, "R3", "request while busy ignored", n_st - s0, 1);
  endtask

  task automatic t_invalid_sel();
    int s0;
    ch_sel = 3'd3; tick(2);
    ch_sel = 3'd6; tick(2);
    s0 = n_st;
    pulse_start(); tick(100);
    chk(st_ch[s0] == 3, "R1", "select above 4 ignored", st_ch[s0], 3);
  endtask

  task automatic t_err();
    int r0;
    err_inject = 1'b1; r0 = n_res;
    pulse_start(); tick(100);
    chk(res_e[r0] == 1, "R4", "error flag carried", res_e[r0], 1);
    err_inject = 1'b0;
    pulse_start(); tick(100);
    chk(res_e[r0 + 1] == 0, "R4", "error flag clear", res_e[r0 + 1], 0);
  endtask

  task automatic t_rr();
    int s0;
    int exp_seq [0:3];
    exp_seq[0] = 1; exp_seq[1] = 2; exp_seq[2] = 4; exp_seq[3] = 1;
    rr_mask = 5'd0; ch_sel = 3'd1; tick(2);
    rr_mask = 5'b10110; tick(1);
    s0 = n_st;
    for (int i = 0; i < 4; i++) begin
      pulse_start(); tick(100);
    end
    for (int i = 0; i < 4; i++)
      chk(st_ch[s0 + i] == exp_seq[i], "R10", "round-robin order", st_ch[s0 + i], exp_seq[i]);
    rr_mask = 5'd0; ch_sel = 3'd3; tick(2);
    rr_mask = 5'b01000; tick(1);
    s0 = n_st;
    for (int i = 0; i < 2; i++) begin
      pulse_start(); tick(100);
    end
    chk(st_ch[s0] == 3 && st_ch[s0 + 1] == 3, "R10", "single-bit mask stays",
        st_ch[s0 + 1], 3);
    rr_mask = 5'd0;
  endtask

  // Free run with a given divider; checks first launch and the spacing.
  task automatic t_run(input int di, input int df, input int nper, input string req);
    int c, s0, r0, acc, per, exp_gap;
    div_int = 16'(di); div_frac = 8'(df);
    tick(1);
    s0 = n_st; r0 = n_res; c = cyc;
    run_en = 1'b1;
    tick(1);
    while (n_st < s0 + nper + 1) tick(1);
    run_en = 1'b0;
    tick(250);
    chk(st_at[s0] == c + 1, "R5", "first free-run strobe", st_at[s0], c + 1);
    acc = 0;
    for (int i = 0; i < nper; i++) begin
      acc = acc + df;
      per = 1 + di + (acc >= 256 ? 1 : 0);
      acc = acc % 256;
      exp_gap = (per < 96) ? 96 : per;
      chk(st_at[s0 + i + 1] - st_at[s0 + i] == exp_gap, req, "strobe spacing",
          st_at[s0 + i + 1] - st_at[s0 + i], exp_gap);
    end
    if (di == 0 && df == 0)
      chk(st_at[s0 + 1] == res_at[r0] + 1, "R6", "back-to-back after result",
          st_at[s0 + 1], res_at[r0] + 1);
    s0 = n_st;
    tick(300);
    chk(n_st == s0, "R5", "no strobe after run cleared", n_st - s0, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_single();
    t_busy_ignore();
    t_invalid_sel();
    t_err();
    t_rr();
    t_run(0, 0, 3, "R6");
    t_run(10, 0, 3, "R8");
    t_run(200, 0, 3, "R7");
    t_run(150, 128, 4, "R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule